// File: doc/BRIEF.md
# SPI Master Transmit Engine with Data Queue

This block is the transmit side of an SPI master. A DMA engine fills a 16-entry queue of bytes. The block serialises each byte onto MOSI, most significant bit first, while the active-low select line is held low. It runs in SPI mode 0: SCK idles low, and MOSI changes only while SCK is low, so the receiving device samples on the rising edge. A baud generator sets the SCK rate. It is made of a 5-bit prescaler (divide by `presc + 1`) followed by a power-of-two divider (divide by `2^div_sel`). Each baud tick moves SCK by half a period.

Software raises the controls in order: first `clk_en`, which runs the baud generator, then `fsync_en`, which releases the frame logic from its idle state, then `tx_en`. Even with all three set, SCK stays low and the select line stays high until a byte is in the queue. Each byte forms its own frame, and the select line returns high between bytes. `dreq` asks the DMA engine for more data while the queue level is at or below a programmed threshold. `fifo_empty` lets software poll for the end of a transfer. A high pulse on `tx_rst` clears the baud generator's counters, so the next transfer starts from a known phase.

Top module: `spi_tx_fifo`

## Requirements
- R1: After reset, SCK is 0, `ss_n` is 1, `dreq` is 0 while `dreq_en` is 0, `fifo_empty` is 1 and `overflow` is 0.
- R2: Each byte taken from the queue is sent as one frame. `ss_n` is low for exactly 8 rising SCK edges, the bits go out MSB first, and MOSI changes only while SCK is low.
- R3: A frame starts, with `ss_n` falling and SCK later toggling, only while `clk_en`, `fsync_en` and `tx_en` are all 1 and the queue holds at least one byte. Otherwise SCK stays 0 and `ss_n` stays 1.
- R4: While a frame runs, successive rising SCK edges are exactly 2*(presc+1)*2^div_sel clock cycles apart.
- R5: The queue holds 16 bytes and sends them in the order written. A write while the queue holds 16 bytes is dropped and sets `overflow`, which stays 1 until reset.
- R6: `dreq` is 1 exactly when `dreq_en` is 1 and the queue level is less than or equal to `threshold`.
- R7: `fifo_empty` is 1 exactly when the queue holds no bytes.
- R8: When `fsync_en` is 0, `ss_n` is 1 and SCK is 0 one cycle later, and any partly sent byte is abandoned.
- R9: If `tx_en` falls during a frame, that byte still completes all 8 bits, and no further frame starts while `tx_en` stays 0.
- R10: A clock cycle with `tx_rst` high clears the baud counters. The next baud tick, at which a pending frame can start, falls exactly (presc+1)*2^div_sel cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Runs the baud generator |
| fsync_en | input | 1 | Releases the frame logic from idle |
| tx_en | input | 1 | Allows new frames to start |
| tx_rst | input | 1 | Clears the baud counters while high |
| presc | input | 5 | Prescaler value; divides by presc+1 |
| div_sel | input | 3 | Power-of-two divider exponent |
| threshold | input | 5 | Queue level at or below which `dreq` is raised |
| dreq_en | input | 1 | Enables the DMA request |
| wr_en | input | 1 | Writes one byte into the queue |
| wr_data | input | 8 | Byte to be queued |
| sck | output | 1 | Serial clock, idle low |
| ss_n | output | 1 | Active-low select, low for one byte |
| mosi | output | 1 | Serial data out, MSB first |
| dreq | output | 1 | Transmit data request to the DMA engine |
| fifo_empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | Sticky flag: a write to a full queue was dropped |

## Verification
The assertions assume that `presc` and `div_sel` stay constant while a frame is in flight, and that `tx_rst` is high only while no frame runs. If the divider changes in mid-frame, the spacing of SCK edges is undefined. The bench changes the divider and pulses the reset only while the select line is high, with `tx_en` at 0 or the queue empty. A scoreboard queue records every byte the driver expects to be sent. The monitor rebuilds each frame from MOSI at the rising SCK edges. The one frame that the bench aborts on purpose is flagged in advance, and the monitor discards it.

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int PW    = 5,
  parameter int DVW   = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int DCW  = (1 << DVW) - 1,
  localparam int BW   = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clk_en,
  input  logic           fsync_en,
  input  logic           tx_en,
  input  logic           tx_rst,
  input  logic [PW-1:0]  presc,
  input  logic [DVW-1:0] div_sel,
  input  logic [CW-1:0]  threshold,
  input  logic           dreq_en,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic           sck,
  output logic           ss_n,
  output logic           mosi,
  output logic           dreq,
  output logic           fifo_empty,
  output logic           overflow
);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  level;
  logic [PW-1:0]  pre_cnt;
  logic [DCW-1:0] div_cnt;
  logic [DW-1:0]  shreg;
  logic [BW-1:0]  bit_cnt;
  logic           active;

  wire full = (level == CW'(DEPTH));
  wire push = wr_en && !full;
  wire [DCW-1:0] mask = (DCW'(1) << div_sel) - DCW'(1);
  wire pre_wrap = (pre_cnt == presc);
  wire tick = clk_en && !tx_rst && pre_wrap && ((div_cnt & mask) == mask);
  wire start = !active && tick && fsync_en && tx_en && !fifo_empty;

  assign fifo_empty = (level == '0);
  assign dreq = dreq_en && (level <= threshold);
  assign ss_n = !active;
  assign mosi = shreg[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n || tx_rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (clk_en) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + PW'(1);
      if (pre_wrap) div_cnt <= div_cnt + DCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (start) rd_ptr <= rd_ptr + AW'(1);
      if (push && !start) level <= level + CW'(1);
      else if (start && !push) level <= level - CW'(1);
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sck     <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!fsync_en) begin
      active <= 1'b0;
      sck    <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      sck     <= 1'b0;
      shreg   <= mem[rd_ptr];
      bit_cnt <= '0;
    end else if (active && tick) begin
      if (!sck) begin
        sck <= 1'b1;
      end else begin
        sck <= 1'b0;
        if (bit_cnt == BW'(DW-1)) active <= 1'b0;
        else begin
          shreg   <= shreg << 1;
          bit_cnt <= bit_cnt + BW'(1);
        end
      end
    end
  end

  // R1 / R3: SCK only moves inside a frame
  a_r1_sck_idle: assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> !sck);
  // R3: a frame opens only with data queued and all enables set
  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(!fifo_empty && tx_en && fsync_en && clk_en));
  // R2: mode 0, data held while SCK is high
  a_r2_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && sck) |-> $stable(mosi));
  // R5: overflow is sticky
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8: frame abort on fsync_en low
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_en |=> (ss_n && !sck));
  // R7: an empty queue never shrinks
  a_r7_empty_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !wr_en) |=> fifo_empty);

endmodule

// File: tb/sim_spi_tx_fifo.sv
module sim_spi_tx_fifo;
  logic clk = 0, rst_n = 0;
  logic clk_en = 0, fsync_en = 0, tx_en = 0, tx_rst = 0, dreq_en = 0, wr_en = 0;
  logic [4:0] presc = 5'd1, threshold = 5'd4;
  logic [2:0] div_sel = 3'd1;
  logic [7:0] wr_data = '0;
  logic sck, ss_n, mosi, dreq, fifo_empty, overflow;

  int checks = 0, errors = 0, cyc = 0;
  int frames = 0, rises = 0, last_period = 0, last_rise = 0, nbits = 0;
  bit expect_partial = 0, prev_sck = 0, prev_ss = 1, done = 0;
  logic [7:0] bits;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  spi_tx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .fsync_en(fsync_en), .tx_en(tx_en),
    .tx_rst(tx_rst), .presc(presc), .div_sel(div_sel), .threshold(threshold),
    .dreq_en(dreq_en), .wr_en(wr_en), .wr_data(wr_data), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .dreq(dreq), .fifo_empty(fifo_empty), .overflow(overflow));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (prev_ss && !ss_n) begin frames++; nbits = 0; end
      if (!ss_n && sck && !prev_sck) begin
        rises++;
        if (nbits > 0) last_period = cyc - last_rise;
        last_rise = cyc;
        bits = {bits[6:0], mosi};
        nbits++;
      end
      if (!prev_ss && ss_n) begin
        if (expect_partial) begin
          if (exp_q.size() > 0) void'(exp_q.pop_front());
          expect_partial = 0;
        end else if (exp_q.size() == 0) begin
          check(0, "R2 unexpected frame", bits, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(nbits == 8, "R2 bits per frame", nbits, 8);
          check(bits == e, "R2/R5 frame data", bits, e);
        end
      end
      prev_sck = sck;
      prev_ss = ss_n;
    end
  end

  task automatic write_byte(input logic [7:0] d, input bit expected);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (expected) exp_q.push_back(d);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && (exp_q.size() > 0 || !ss_n); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    int f0, n;
    repeat (3) @(negedge clk);
    check(sck == 0 && ss_n == 1, "R1 sck/ss_n", {sck, ss_n}, 1);
    check(dreq == 0 && fifo_empty == 1 && overflow == 0, "R1 flags",
          {dreq, fifo_empty, overflow}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    check(sck == 0 && ss_n == 1 && fifo_empty && !overflow, "R1 after reset", ss_n, 1);

    dreq_en = 1; @(negedge clk);
    check(dreq == 1, "R6 dreq at level 0", dreq, 1);

    // R3: all enables, empty queue: no clock, no frame
    clk_en = 1; fsync_en = 1; tx_en = 1;
    repeat (60) @(negedge clk);
    check(rises == 0 && frames == 0 && ss_n, "R3 no sck without data", rises, 0);

    // R3: data present but tx_en low
    tx_en = 0;
    write_byte(8'hA5, 1); write_byte(8'h3C, 1); write_byte(8'hF0, 1);
    repeat (60) @(negedge clk);
    check(frames == 0, "R3 no frame with tx_en low", frames, 0);
    check(fifo_empty == 0, "R7 not empty at level 3", fifo_empty, 0);
    check(dreq == 1, "R6 dreq at level 3, thr 4", dreq, 1);
    write_byte(8'h01, 1); write_byte(8'h80, 1);
    check(dreq == 0, "R6 dreq at level 5, thr 4", dreq, 0);
    tx_en = 1;
    drain();
    check(last_period == 8, "R4 period presc1 div1", last_period, 8);
    check(fifo_empty == 1, "R7 empty after drain", fifo_empty, 1);

    // R4: other divider
    tx_en = 0; presc = 5'd2; div_sel = 3'd0; @(negedge clk);
    write_byte(8'h5A, 1); tx_en = 1;
    drain();
    check(last_period == 6, "R4 period presc2 div0", last_period, 6);

    // R5: overflow
    tx_en = 0; presc = 5'd1; div_sel = 3'd1;
    for (int i = 0; i < 17; i++) write_byte(8'(i * 13 + 7), i < 16);
    check(overflow == 1, "R5 overflow set", overflow, 1);
    check(dreq == 0, "R6 dreq full", dreq, 0);
    tx_en = 1;
    drain();
    check(overflow == 1, "R5 overflow sticky", overflow, 1);

    // R9: tx_en drop mid-frame
    tx_en = 0;
    write_byte(8'hC3, 1); write_byte(8'h96, 1);
    f0 = frames; tx_en = 1;
    while (ss_n) @(negedge clk);
    repeat (10) @(negedge clk);
    tx_en = 0;
    repeat (200) @(negedge clk);
    check(frames == f0 + 1, "R9 one frame only", frames - f0, 1);
    check(exp_q.size() == 1 && !fifo_empty, "R9 second byte kept", exp_q.size(), 1);
    tx_en = 1;
    drain();

    // R8: abort with fsync_en
    write_byte(8'hE7, 1); expect_partial = 1;
    while (ss_n) @(negedge clk);
    repeat (12) @(negedge clk);
    fsync_en = 0;
    @(negedge clk);
    check(ss_n == 1 && sck == 0, "R8 abort", {ss_n, sck}, 2);
    repeat (20) @(negedge clk);
    check(ss_n == 1 && fifo_empty, "R8 stays idle", ss_n, 1);
    fsync_en = 1;

    // R10: baud reset phase
    tx_en = 0;
    write_byte(8'h69, 1);
    repeat (3) @(negedge clk);
    tx_rst = 1; @(negedge clk);
    tx_rst = 0; tx_en = 1;
    n = 0;
    while (ss_n && n < 100) begin @(negedge clk); n++; end
    check(n == 4, "R10 start after tx_rst", n, 4);
    drain();

    done = 1;
    finish_run();
  end
endmodule